// File: doc/BRIEF.md
# Interleaved Half-Band Decimating Filter

The block low-pass filters several time-interleaved sample streams with a fixed, symmetric 11-tap half-band response and keeps every second result of each stream. Samples arrive one per clock at most, each marked by a valid gate. The streams take turns in a fixed round-robin order that advances only on valid cycles. Every stream keeps its own history, so the streams never mix. The coefficients are built from shifts and adds, so the block uses no multipliers.

A caller feeds `din` together with `din_vld`, in stream order 0, 1, …, NSTR-1, 0, 1, and so on. The decimated results leave on `dout` with `dout_vld` set. They come out as a run of NSTR words, one per stream in stream order, and then NSTR valid inputs produce no output. The filter response can rise slightly above full scale. The result is therefore rounded and clamped to the 20-bit signed range.

Top module: `hb_decim`

## Requirements
- R1: For each stream, with x[k] that stream's k-th most recent valid sample (x[0] the current one), the pre-rounding sum is 2(x[0]+x[10]) - 9(x[2]+x[8]) + 39(x[4]+x[6]) + 64x[5]. The output is (sum + 64) shifted right arithmetically by 7. Samples are two's complement, and history is zero after reset.
- R2: A constant input c on a stream gives exactly c at the output once that stream has 11 samples of history.
- R3: A cycle with `din_vld` low has no effect on the result. It advances neither the stream index nor any history, and its `din` value is ignored.
- R4: After reset, the 1st, 3rd, 5th… valid samples of each stream give no output. The 2nd, 4th, 6th… samples each give one output word.
- R5: An output word appears on `dout` with `dout_vld` high exactly 4 clock cycles after the input cycle that completes it. `dout_vld` is low in every other cycle.
- R6: Each stream is filtered only from its own samples. A sample on one stream never changes the output of another stream.
- R7: A result above 524287 is output as 524287, and a result below -524288 is output as -524288.
- R8: A synchronous reset (`rst` high at a clock edge) returns the stream index to 0, the decimation phase to "no output", the history to zero, and `dout_vld` to low from the next cycle.
- R9: Valid samples can be given on every cycle without a gap, and each one is processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 20 | Signed input sample |
| din_vld | input | 1 | Input sample valid |
| dout | output | 20 | Signed, rounded, saturated output sample |
| dout_vld | output | 1 | Output sample valid |

## Verification
The most delicate coincidence is a gate-low cycle that falls on the cycle that would wrap the stream index and flip the decimation phase. At the same time, a burst of decimated words from the previous phase is still leaving the 4-stage pipeline. The bench provokes this by dropping `din_vld` in irregular patterns while driving junk data, and by resetting in the middle of a burst. A stream-by-stream model judges the result: it predicts the gate and the value in every cycle, 4 cycles after each input.

// File: rtl/hb_decim.sv
module hb_decim #(
  parameter int NSTR = 4,
  parameter int DW   = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [DW-1:0] din,
  input  logic                 din_vld,
  output logic signed [DW-1:0] dout,
  output logic                 dout_vld
);
  localparam int SPAN  = 10;
  localparam int DEPTH = SPAN * NSTR;
  localparam int IW    = (NSTR > 1) ? $clog2(NSTR) : 1;
  localparam int AW    = DW + 10;
  localparam logic signed [AW-1:0] MAXV = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] MINV = -(AW'(1) <<< (DW - 1));

  logic signed [DW-1:0] hist [DEPTH];
  logic [IW-1:0] idx;
  logic          phase;

  logic signed [AW-1:0] sa, sb, sc, sm, p1, p2, acc, q;
  logic                 v1, v2, v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      phase <= 1'b0;
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (din_vld) begin
      hist[0] <= din;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
      if (idx == IW'(NSTR - 1)) begin
        idx   <= '0;
        phase <= ~phase;
      end else begin
        idx <= idx + IW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      v1 <= din_vld & phase;
      v2 <= v1;
      v3 <= v2;
      dout_vld <= v3;
    end
  end

  assign q = acc >>> 7;

  always_ff @(posedge clk) begin
    sa  <= AW'(din) + AW'(hist[10*NSTR-1]);
    sb  <= AW'(hist[2*NSTR-1]) + AW'(hist[8*NSTR-1]);
    sc  <= AW'(hist[4*NSTR-1]) + AW'(hist[6*NSTR-1]);
    sm  <= AW'(hist[5*NSTR-1]);
    p1  <= (sa <<< 1) - (sb <<< 3) - sb;
    p2  <= (sc <<< 5) + (sc <<< 3) - sc + (sm <<< 6);
    acc <= p1 + p2 + AW'(64);
    if (q > MAXV)      dout <= MAXV[DW-1:0];
    else if (q < MINV) dout <= MINV[DW-1:0];
    else               dout <= q[DW-1:0];
  end
endmodule

// File: rtl/hb_decim_chk.sv
module hb_decim_chk #(
  parameter int NSTR = 4,
  parameter int DW   = 20,
  localparam int IW  = (NSTR > 1) ? $clog2(NSTR) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          din_vld,
  input logic          dout_vld,
  input logic [IW-1:0] idx
);
  logic [IW:0] cnt;
  logic [3:0]  emit_d;
  logic        emit;

  assign emit = din_vld && (cnt >= (IW+1)'(NSTR));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      emit_d <= '0;
    end else begin
      emit_d <= {emit_d[2:0], emit};
      if (din_vld) cnt <= (cnt == (IW+1)'(2*NSTR-1)) ? '0 : cnt + (IW+1)'(1);
    end
  end

  AST_OUT_NEEDS_EMIT: assert property (@(posedge clk) disable iff (rst) dout_vld |-> emit_d[3]); // R4
  AST_EMIT_YIELDS_OUT: assert property (@(posedge clk) disable iff (rst) emit_d[3] |-> dout_vld); // R5
  AST_IDLE_HOLDS_INDEX: assert property (@(posedge clk) disable iff (rst) !din_vld |=> $stable(idx)); // R3
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst) idx <= IW'(NSTR - 1)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !dout_vld); // R8
endmodule

bind hb_decim hb_decim_chk #(.NSTR(NSTR), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .din_vld(din_vld), .dout_vld(dout_vld), .idx(idx)
);

// File: tb/test_hb_decim.sv
module test_hb_decim;
  localparam int NSTR = 4;
  localparam int NV   = 32;
  localparam logic [20:0] VEC [NV] = '{
    21'h10400, 21'h1FF000, 21'h10001, 21'h00000, 21'h17FFFF, 21'h0ABCDE, 21'h10000, 21'h10000,
    21'h10000, 21'h10000, 21'h1003F, 21'h0FFFFF, 21'h1FFFC1, 21'h10080, 21'h10000, 21'h10000,
    21'h10123, 21'h0DEAD0, 21'h12000, 21'h1F0000, 21'h15555, 21'h1AAAAA, 21'h00001, 21'h10000,
    21'h10000, 21'h10010, 21'h10000, 21'h0FFFF0, 21'h10000, 21'h1FFFFF, 21'h10000, 21'h1000A
  };

  logic clk = 1'b0, rst = 1'b1, din_vld = 1'b0;
  logic signed [19:0] din = '0, dout;
  logic dout_vld;
  int checks = 0, fails = 0;
  bit done = 0;

  longint hist [NSTR][11];
  bit ph [NSTR];
  int sidx;
  bit pv [4];
  logic signed [19:0] pd [4];

  always #4 clk = ~clk;

  hb_decim #(.NSTR(NSTR), .DW(20)) i_hb_decim (
    .clk(clk), .rst(rst), .din(din), .din_vld(din_vld), .dout(dout), .dout_vld(dout_vld)
  );

  function automatic logic signed [19:0] ref_out(int s);
    longint acc, q;
    acc = 2*(hist[s][0]+hist[s][10]) - 9*(hist[s][2]+hist[s][8])
        + 39*(hist[s][4]+hist[s][6]) + 64*hist[s][5] + 64;
    q = acc >>> 7;
    if (q > 524287) q = 524287;
    if (q < -524288) q = -524288;
    return 20'(q);
  endfunction

  task automatic model_clear();
    sidx = 0;
    for (int s = 0; s < NSTR; s++) begin
      ph[s] = 0;
      for (int k = 0; k < 11; k++) hist[s][k] = 0;
    end
    for (int i = 0; i < 4; i++) begin pv[i] = 0; pd[i] = '0; end
  endtask

  task automatic step(input logic v, input logic signed [19:0] d, input string req);
    @(negedge clk);
    checks++;
    if (dout_vld !== pv[3] || (pv[3] && dout !== pd[3])) begin
      fails++;
      $display("FAIL %s: gate=%0b data=%0d expected gate=%0b data=%0d", req, dout_vld, dout, pv[3], pd[3]);
    end
    for (int i = 3; i > 0; i--) begin pv[i] = pv[i-1]; pd[i] = pd[i-1]; end
    pv[0] = 0; pd[0] = '0;
    if (v) begin
      for (int k = 10; k > 0; k--) hist[sidx][k] = hist[sidx][k-1];
      hist[sidx][0] = longint'(d);
      if (ph[sidx]) begin pv[0] = 1; pd[0] = ref_out(sidx); end
      ph[sidx] = !ph[sidx];
      sidx = (sidx + 1) % NSTR;
    end
    din = d;
    din_vld = v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; din_vld = 1'b0;
    model_clear();
    @(negedge clk);
    checks++;
    if (dout_vld !== 1'b0) begin
      fails++;
      $display("FAIL R8: gate=%0b expected gate=0 after reset", dout_vld);
    end
    rst = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 6; i++) step(1'b0, 20'sh5A5A5, req);
  endtask

  initial begin
    model_clear();
    do_reset();

    // R1 R6 R3: table walk, impulses on separate streams, gaps with junk data
    for (int i = 0; i < NV; i++) step(VEC[i][20], VEC[i][19:0], "R1/R6");
    drain("R1");

    // R2 R9: per-stream constants back to back
    do_reset();
    for (int j = 0; j < 14; j++)
      for (int s = 0; s < NSTR; s++) begin
        logic signed [19:0] c;
        c = (s == 0) ? 20'sd1000 : (s == 1) ? -20'sd2000 : (s == 2) ? 20'sd524287 : -20'sd524288;
        step(1'b1, c, "R2/R9");
      end
    drain("R2");

    // R3: irregular gate, junk on idle cycles
    do_reset();
    for (int j = 0; j < 60; j++) begin
      if ((j % 3) == 1 || (j % 7) == 5) step(1'b0, 20'(j * 40503), "R3");
      else step(1'b1, 20'(j * 1237 - 30000), "R3");
    end
    drain("R3");

    // R7: saturation both ways
    do_reset();
    for (int j = 0; j < 12; j++)
      for (int s = 0; s < NSTR; s++) begin
        logic signed [19:0] v;
        v = '0;
        if (j == 1 || j == 5 || j == 6 || j == 7 || j == 11) v = 20'sd524287;
        if (j == 3 || j == 9) v = -20'sd524288;
        if (s == 1) v = (v == 20'sd524287) ? -20'sd524288 : (v != 0) ? 20'sd524287 : '0;
        if (s >= 2) v = '0;
        step(1'b1, v, "R7");
      end
    drain("R7");

    // R8 R4: reset in the middle of an output burst, then restart
    for (int j = 0; j < 10; j++) step(1'b1, 20'(j * 5000 + 100), "R4");
    do_reset();
    for (int j = 0; j < 20; j++) step(1'b1, 20'(7000 - j * 333), "R8/R4");
    drain("R8");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule